// File: doc/BRIEF.md
# Grouped Packet Statistics Counter Bank

This block keeps four traffic counts for a port: transmitted packets, transmit error packets, received packets and receive error packets. Each category is fed by a one-cycle event pulse. A host reads the counts as six `REG_W`-bit words through a simple read port. Each read is an address plus a strobe, and the word comes back one cycle later.

The six words form two groups of three. The transmit group is the packet count low word, then its high word, then the error count. The receive group has the same layout. Reading the first word of a group freezes that group, so the three words form one consistent snapshot. Events that arrive while a group is frozen collect in a shadow accumulator. The group clears only when its three words are read strictly in order. When the group unfreezes, the shadow amount is added back in, so no event is lost. Any other read order releases the group without clearing it. All counts stop at their maximum value and do not wrap.

Top module: `pktstat_bank`

## Requirements
- R1: After a synchronous reset, every count is zero, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` rises exactly one cycle after a cycle with `rd_en` high and is 0 otherwise. A read of an address outside `BASE_ADDR`..`BASE_ADDR+5` returns 0.
- R3: The word at `BASE_ADDR+n` is selected as follows:
  - n=0: bits `REG_W-1:0` of the transmit packet count.
  - n=1: the upper `REG_W` bits of the transmit packet count.
  - n=2: the transmit error count.
  - n=3, 4 and 5: the same three fields for the receive direction.
- R4: In a group that is not frozen, each cycle with a packet pulse adds one to the packet count. Each cycle with an error pulse adds one to the error count.
- R5: A read of a group's first word while the group is not frozen freezes the group. The group's counts then stay unchanged until it unfreezes, and its later words return that snapshot.
- R6: Reading words 1, 2 and 3 of a frozen group in consecutive read accesses clears the group. Only events that arrived after the first of those reads remain.
- R7: A read of one of the group's own words out of the expected order unfreezes the group without clearing it. This includes repeating the first word. A sequence such as 1,2,1,2,3 therefore leaves the counts intact.
- R8: While a group is frozen, a read of any address outside that group unfreezes it without clearing it. The two groups never affect each other's counts.
- R9: Events that arrive during a freeze are added to the counts when the group unfreezes, whether or not it was cleared.
- R10: Packet counts stop at 2^(2*`REG_W`)-1 and error counts stop at 2^`REG_W`-1 instead of wrapping.
- R11: A read of word 2 or 3 of a group that is not frozen returns the live value and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pkt_ev | input | 1 | One transmitted packet this cycle |
| tx_err_ev | input | 1 | One transmit error packet this cycle |
| rx_pkt_ev | input | 1 | One received packet this cycle |
| rx_err_ev | input | 1 | One receive error packet this cycle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | REG_W | Registered read word |

## Verification
In-order reads of each group with events held back confirm the field layout and the clear. In-order reads with events injected mid-sequence separate a true snapshot-and-shadow from a design that simply drops or counts through frozen events. The broken orders used are a repeated first word, a jump to the other group, and a lone read of the error word. They tell a strict sequence tracker apart from one that only checks that the last word was reached. A second instance with `REG_W`=4 is driven past both limits to expose wrapping. Long random traffic mixed with random and in-order reads covers the interleavings between the two groups.

// File: rtl/pktstat_pkg.sv
package pktstat_pkg;
  localparam int GROUP_REGS = 3;
  localparam int NUM_GROUPS = 2;

  typedef enum logic [1:0] {
    POS_IDLE = 2'd0,
    POS_HI   = 2'd1,
    POS_ERR  = 2'd2
  } seq_pos_e;
endpackage

// File: rtl/pktstat_satadd.sv
module pktstat_satadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inc,
  output logic [W-1:0] y
);
  localparam logic [W+1:0] LIMIT = {2'b00, {W{1'b1}}};

  logic [W+1:0] sum;

  assign sum = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, inc};
  assign y   = (sum > LIMIT) ? {W{1'b1}} : sum[W-1:0];
endmodule

// File: rtl/pktstat_group.sv
module pktstat_group
  import pktstat_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkt_ev,
  input  logic               err_ev,
  input  logic               acc_en,
  input  logic               acc_hit,
  input  logic [1:0]         acc_idx,
  output logic [REG_W-1:0]   rd_word,
  output logic               frozen,
  output logic [2*REG_W-1:0] pkt_cnt,
  output logic [REG_W-1:0]   err_cnt
);
  localparam int PKT_W = 2 * REG_W;
  localparam int ERR_W = REG_W;

  logic [PKT_W-1:0] pkt_q, sh_pkt_q, pkt_base, pkt_add, pkt_sum, sh_pkt_sum;
  logic [ERR_W-1:0] err_q, sh_err_q, err_base, err_add, err_sum, sh_err_sum;
  logic             frozen_q;
  seq_pos_e         pos_q;

  logic start, in_order, finish, brk, unfreeze, live, hold;

  // sequence decode
  assign start    = acc_en & acc_hit & (acc_idx == 2'd0) & ~frozen_q;
  assign in_order = acc_en & acc_hit & frozen_q & (acc_idx == pos_q);
  assign finish   = in_order & (pos_q == POS_ERR);
  assign brk      = acc_en & frozen_q & ~in_order;
  assign unfreeze = finish | brk;
  assign live     = ~frozen_q & ~start;
  assign hold     = start | (frozen_q & ~unfreeze);

  // one adder per count serves both live counting and the shadow merge
  assign pkt_base = finish   ? '0 : pkt_q;
  assign pkt_add  = unfreeze ? sh_pkt_q : '0;
  assign err_base = finish   ? '0 : err_q;
  assign err_add  = unfreeze ? sh_err_q : '0;

  pktstat_satadd #(.W(PKT_W)) u_pkt_add (
    .a(pkt_base), .b(pkt_add), .inc(pkt_ev), .y(pkt_sum));
  pktstat_satadd #(.W(ERR_W)) u_err_add (
    .a(err_base), .b(err_add), .inc(err_ev), .y(err_sum));
  pktstat_satadd #(.W(PKT_W)) u_shp_add (
    .a(sh_pkt_q), .b({PKT_W{1'b0}}), .inc(pkt_ev), .y(sh_pkt_sum));
  pktstat_satadd #(.W(ERR_W)) u_she_add (
    .a(sh_err_q), .b({ERR_W{1'b0}}), .inc(err_ev), .y(sh_err_sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q    <= '0;
      err_q    <= '0;
      sh_pkt_q <= '0;
      sh_err_q <= '0;
      frozen_q <= 1'b0;
      pos_q    <= POS_IDLE;
    end else begin
      if (live | unfreeze) begin
        pkt_q <= pkt_sum;
        err_q <= err_sum;
      end
      if (unfreeze) begin
        sh_pkt_q <= '0;
        sh_err_q <= '0;
      end else if (hold) begin
        sh_pkt_q <= sh_pkt_sum;
        sh_err_q <= sh_err_sum;
      end
      frozen_q <= (frozen_q & ~unfreeze) | start;
      if (start)
        pos_q <= POS_HI;
      else if (unfreeze)
        pos_q <= POS_IDLE;
      else if (in_order)
        pos_q <= POS_ERR;
    end
  end

  always_comb begin
    case (acc_idx)
      2'd0:    rd_word = pkt_q[REG_W-1:0];
      2'd1:    rd_word = pkt_q[PKT_W-1:REG_W];
      default: rd_word = err_q;
    endcase
  end

  assign frozen  = frozen_q;
  assign pkt_cnt = pkt_q;
  assign err_cnt = err_q;
endmodule

// File: rtl/pktstat_bank.sv
module pktstat_bank
  import pktstat_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h12B,
  parameter int                REG_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pkt_ev,
  input  logic              tx_err_ev,
  input  logic              rx_pkt_ev,
  input  logic              rx_err_ev,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data
);
  localparam int PKT_W = 2 * REG_W;

  logic [ADDR_W-1:0]                  ofs;
  logic [NUM_GROUPS-1:0]              pkt_ev_v, err_ev_v, grp_hit, grp_frozen;
  logic [NUM_GROUPS-1:0][1:0]         grp_idx;
  logic [NUM_GROUPS-1:0][REG_W-1:0]   grp_word;
  logic [NUM_GROUPS-1:0][PKT_W-1:0]   grp_pkt;
  logic [NUM_GROUPS-1:0][REG_W-1:0]   grp_err;
  logic [REG_W-1:0]                   rd_mux;

  assign ofs      = rd_addr - BASE_ADDR;
  assign pkt_ev_v = {rx_pkt_ev, tx_pkt_ev};
  assign err_ev_v = {rx_err_ev, tx_err_ev};

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(GROUP_REGS * g);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(GROUP_REGS * (g + 1));
    logic [ADDR_W-1:0] rel;

    assign rel        = ofs - LO;
    assign grp_hit[g] = (ofs >= LO) && (ofs < HI);
    assign grp_idx[g] = rel[1:0];

    pktstat_group #(.REG_W(REG_W)) u_group (
      .clk     (clk),
      .rst     (rst),
      .pkt_ev  (pkt_ev_v[g]),
      .err_ev  (err_ev_v[g]),
      .acc_en  (rd_en),
      .acc_hit (grp_hit[g]),
      .acc_idx (grp_idx[g]),
      .rd_word (grp_word[g]),
      .frozen  (grp_frozen[g]),
      .pkt_cnt (grp_pkt[g]),
      .err_cnt (grp_err[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp_hit[g]) rd_mux = grp_word[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pktstat_bank_chk.sv
module pktstat_bank_chk
  import pktstat_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h12B,
  parameter int                REG_W     = 16
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                rd_en,
  input logic [ADDR_W-1:0]                   rd_addr,
  input logic                                rd_valid,
  input logic [REG_W-1:0]                    rd_data,
  input logic [NUM_GROUPS-1:0]               grp_frozen,
  input logic [NUM_GROUPS-1:0][2*REG_W-1:0]  grp_pkt
);
  logic [ADDR_W-1:0] c_ofs;
  logic              c_mapped;

  assign c_ofs    = rd_addr - BASE_ADDR;
  assign c_mapped = c_ofs < ADDR_W'(GROUP_REGS * NUM_GROUPS);

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !c_mapped) |=> (rd_data == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    logic in_grp, first_hit;
    assign in_grp    = (c_ofs >= ADDR_W'(GROUP_REGS * g)) &&
                       (c_ofs <  ADDR_W'(GROUP_REGS * (g + 1)));
    assign first_hit = rd_en && (c_ofs == ADDR_W'(GROUP_REGS * g));

    // R5
    a_r5_first_read_freezes: assert property (@(posedge clk) disable iff (rst)
      (first_hit && !grp_frozen[g]) |=> grp_frozen[g]);
    a_r5_frozen_stable: assert property (@(posedge clk) disable iff (rst)
      (grp_frozen[g] ##1 grp_frozen[g]) |-> $stable(grp_pkt[g]));
    // R8
    a_r8_outside_unfreezes: assert property (@(posedge clk) disable iff (rst)
      (grp_frozen[g] && rd_en && !in_grp) |=> !grp_frozen[g]);
    // R10
    a_r10_pkt_saturates: assert property (@(posedge clk) disable iff (rst)
      (!grp_frozen[g] && (grp_pkt[g] == '1) && !first_hit) |=> (grp_pkt[g] == '1));
  end
endmodule

bind pktstat_bank pktstat_bank_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REG_W(REG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .grp_frozen (grp_frozen),
  .grp_pkt    (grp_pkt)
);

// File: tb/pktstat_bank_tb.sv
module pktstat_bank_tb;
  localparam int BASE = 'h12B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_pkt_ev = 0, tx_err_ev = 0, rx_pkt_ev = 0, rx_err_ev = 0;
  logic        rd_en = 0;
  logic [11:0] rd_addr = '0;
  logic        rd_valid, s_valid;
  logic [15:0] rd_data;
  logic [3:0]  s_data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pktstat_bank u_dut (
    .clk(clk), .rst(rst), .tx_pkt_ev(tx_pkt_ev), .tx_err_ev(tx_err_ev),
    .rx_pkt_ev(rx_pkt_ev), .rx_err_ev(rx_err_ev), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  pktstat_bank #(.REG_W(4)) u_sat (
    .clk(clk), .rst(rst), .tx_pkt_ev(tx_pkt_ev), .tx_err_ev(tx_err_ev),
    .rx_pkt_ev(rx_pkt_ev), .rx_err_ev(rx_err_ev), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(s_valid), .rd_data(s_data));

  // reference model: [instance][group]
  longint mp[2][2], me[2][2], sp[2][2], se[2][2];
  bit     mf[2][2];
  int     mpos[2][2];
  int     regw[2] = '{16, 4};

  function automatic longint sat(longint v, longint mx);
    return (v > mx) ? mx : v;
  endfunction

  function automatic longint pmax(int i);
    return (longint'(1) << (2 * regw[i])) - 1;
  endfunction

  function automatic longint emax(int i);
    return (longint'(1) << regw[i]) - 1;
  endfunction

  function automatic longint exp_word(int i, int addr);
    int ofs = addr - BASE;
    int g, k;
    if (ofs < 0 || ofs > 5) return 0;
    g = ofs / 3;
    k = ofs % 3;
    if (k == 0) return mp[i][g] & emax(i);
    if (k == 1) return (mp[i][g] >> regw[i]) & emax(i);
    return me[i][g];
  endfunction

  task automatic mstep(int i, int g, bit ep, bit ee, bit en, int addr);
    int  ofs = addr - BASE;
    bit  hit = en && (ofs >= 3 * g) && (ofs < 3 * g + 3);
    int  k   = ofs - 3 * g;
    longint pm = pmax(i), em = emax(i);
    if (!mf[i][g]) begin
      if (hit && k == 0) begin
        mf[i][g] = 1; mpos[i][g] = 1;
        sp[i][g] = sat(sp[i][g] + ep, pm); se[i][g] = sat(se[i][g] + ee, em);
      end else begin
        mp[i][g] = sat(mp[i][g] + ep, pm); me[i][g] = sat(me[i][g] + ee, em);
      end
    end else if (hit && k == mpos[i][g]) begin
      if (mpos[i][g] == 2) begin
        mp[i][g] = sat(sp[i][g] + ep, pm); me[i][g] = sat(se[i][g] + ee, em);
        sp[i][g] = 0; se[i][g] = 0; mf[i][g] = 0; mpos[i][g] = 0;
      end else begin
        mpos[i][g] = 2;
        sp[i][g] = sat(sp[i][g] + ep, pm); se[i][g] = sat(se[i][g] + ee, em);
      end
    end else if (en) begin
      mp[i][g] = sat(mp[i][g] + sp[i][g] + ep, pm);
      me[i][g] = sat(me[i][g] + se[i][g] + ee, em);
      sp[i][g] = 0; se[i][g] = 0; mf[i][g] = 0; mpos[i][g] = 0;
    end else begin
      sp[i][g] = sat(sp[i][g] + ep, pm); se[i][g] = sat(se[i][g] + ee, em);
    end
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit tp, bit te, bit rp, bit re_, bit en, int addr, string req);
    longint e0, e1;
    tx_pkt_ev = tp; tx_err_ev = te; rx_pkt_ev = rp; rx_err_ev = re_;
    rd_en = en; rd_addr = 12'(addr);
    e0 = exp_word(0, addr);
    e1 = exp_word(1, addr);
    for (int i = 0; i < 2; i++) begin
      mstep(i, 0, tp, te, en, addr);
      mstep(i, 1, rp, re_, en, addr);
    end
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      chk(req, rd_data, e0);
      chk(req, s_data, e1);
      chk("R2", rd_valid, 1);
    end
  endtask

  task automatic rd(int addr, string req);
    cyc(0, 0, 0, 0, 1, addr, req);
  endtask

  task automatic rd_group(int g, string req);
    for (int k = 0; k < 3; k++) rd(BASE + 3 * g + k, req);
  endtask

  task automatic ev(int n, bit tp, bit te, bit rp, bit re_);
    for (int j = 0; j < n; j++) cyc(tp, te, rp, re_, 0, 0, "R4");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BAD5EED));
    for (int i = 0; i < 2; i++)
      for (int g = 0; g < 2; g++) begin
        mp[i][g] = 0; me[i][g] = 0; sp[i][g] = 0; se[i][g] = 0;
        mf[i][g] = 0; mpos[i][g] = 0;
      end
    repeat (3) @(negedge clk);
    chk("R1", rd_valid, 0);
    chk("R1", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", rd_valid, 0);
    for (int a = 0; a < 6; a++) rd(BASE + a, "R1");

    // layout and counting
    ev(5, 1, 0, 0, 0);
    ev(3, 0, 1, 1, 0);
    cyc(0, 0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 1, 0, 0, "R4");
    rd_group(0, "R3");
    rd_group(1, "R3");
    // in-order read cleared both
    rd_group(0, "R6");
    rd_group(1, "R6");

    // snapshot with events during freeze
    ev(3, 1, 0, 0, 0);
    rd(BASE, "R5");
    ev(4, 1, 1, 0, 0);
    rd(BASE + 1, "R5");
    cyc(1, 0, 0, 0, 1, BASE + 2, "R5");
    rd_group(0, "R9");

    // broken order 1,2,1,2,3
    ev(2, 1, 1, 0, 0);
    rd(BASE, "R7"); rd(BASE + 1, "R7"); rd(BASE, "R7");
    rd(BASE + 1, "R7"); rd(BASE + 2, "R7");
    rd_group(0, "R7");

    // read outside group releases it
    ev(2, 1, 0, 1, 0);
    rd(BASE, "R8");
    cyc(1, 0, 0, 0, 0, 0, "R8");
    rd(BASE + 3, "R8");
    ev(1, 1, 0, 0, 0);
    rd_group(0, "R8");
    rd(BASE + 5, "R8");
    rd(BASE + 4, "R8");
    rd_group(1, "R8");

    // lone read of error word while live
    ev(2, 0, 1, 0, 0);
    rd(BASE + 2, "R11");
    rd(BASE + 1, "R11");
    rd_group(0, "R11");

    // unmapped
    rd(BASE - 1, "R2");
    rd(BASE + 6, "R2");
    rd(0, "R2");

    // saturation on the narrow instance
    ev(300, 1, 1, 1, 1);
    rd_group(0, "R10");
    rd_group(1, "R10");
    ev(270, 1, 1, 0, 0);
    rd(BASE, "R10");
    ev(10, 1, 1, 0, 0);
    rd(BASE + 4, "R10");
    rd_group(0, "R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit tp = ($urandom % 3) == 0;
      bit te = ($urandom % 5) == 0;
      bit rp = ($urandom % 3) == 0;
      bit re_ = ($urandom % 5) == 0;
      if (n % 50 == 0) begin
        int g = $urandom % 2;
        for (int k = 0; k < 3; k++) cyc(tp, te, rp, re_, 1, BASE + 3 * g + k, "R6");
      end else begin
        bit en = ($urandom % 3) == 0;
        int addr = BASE - 2 + ($urandom % 10);
        cyc(tp, te, rp, re_, en, addr, "R4");
      end
    end
    rd_group(0, "R4");
    rd_group(1, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule